// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Register Slave

This block lets an external microcontroller reach a small on-chip register file over an 8-bit bus that carries the address first and the data second. A static strap input picks one of two strobe conventions on the same three pins. In the low-active read/write convention, `ale_as` is the address latch strobe, `rd_ds` is an active-low read strobe and `wr_rw` is an active-low write strobe. In the data-strobe convention, `ale_as` is the address strobe, `rd_ds` is an active-high data strobe, and `wr_rw` gives the direction (high reads, low writes). The tri-state pad is modelled as `bus_out` plus `bus_oe`, and every data transfer is qualified by the active-low chip select `cs_n`.

All pins, including the strap, pass through one two-flop synchronizer. A five-state machine then works on the synchronized values. The states are `ST_IDLE` (no address seen since reset), `ST_ADDR` (address strobe high), `ST_ARMED` (address held, waiting for a data strobe), `ST_READ` (driving the bus) and `ST_WRITE` (write strobe active).
- Transitions out of IDLE and ARMED: IDLE goes to ADDR when the address strobe rises. ARMED goes to ADDR on a new address strobe, to READ on a selected read strobe, and to WRITE on a selected write strobe.
- Transitions out of ADDR: ADDR goes to ARMED on the strobe's falling edge and latches the address at that point.
- Transitions out of READ and WRITE: READ goes back to ARMED when the read strobe ends or the select drops. WRITE goes back to ARMED when the write strobe ends, and commits the write if the select is still active. A new address strobe sends either state to ADDR.

Seven read-only status bytes come from a status input port. Twenty writable bytes sit above them.

Top module: `mbs_slave`

## Requirements
- R1: `mode_moto`=0 selects active-low read (`rd_ds`) and write (`wr_rw`) strobes. `mode_moto`=1 selects an active-high data strobe on `rd_ds`, with `wr_rw`=1 meaning read and `wr_rw`=0 meaning write. Both modes give identical register contents and read data.
- R2: The address is taken from `bus_in` as the address strobe `ale_as` falls. It must stay on the bus for at least 3 clock cycles after that fall. Later bus values do not change the latched address.
- R3: A write takes the `bus_in` value seen as the write strobe ends, and stores it into the addressed writable register (0x6C..0x7F). The stored byte reads back unchanged.
- R4: During a selected read, `bus_oe`=1 and `bus_out` carries the addressed byte. `bus_oe` rises on the 3rd rising clock edge after the read strobe becomes active. Whenever `bus_oe`=0, `bus_out`=0x00.
- R5: A read ends when RD rises (mode 0) or DS falls (mode 1). `bus_oe` returns to 0 on the 2nd rising clock edge after that pin change.
- R6: Addresses 0x65..0x6B read `status_in` byte (addr-0x65), where byte k occupies bits [8k+7:8k].
- R7: Writes to addresses 0x65..0x6B and to unmapped addresses change no register. Reads of any address outside 0x65..0x7F return 0x00.
- R8: With `cs_n`=1, a strobe neither drives the bus (`bus_oe` stays 0) nor writes a register.
- R9: After reset, `bus_oe`=0, `bus_out`=0x00 and every writable register reads 0x00.
- R10: `bus_oe` stays 0 throughout the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_moto | input | 1 | Strap: 0 low-active read/write strobes, 1 data strobe plus direction |
| cs_n | input | 1 | Chip select, active low |
| ale_as | input | 1 | Address strobe, active high, address taken on its fall |
| rd_ds | input | 1 | Read strobe (mode 0, active low) or data strobe (mode 1, active high) |
| wr_rw | input | 1 | Write strobe (mode 0, active low) or direction (mode 1, 1 = read) |
| bus_in | input | 8 | Multiplexed address/data bus, input side |
| status_in | input | 56 | Seven status bytes for the read-only addresses |
| bus_out | output | 8 | Read data toward the pad, 0x00 when not driving |
| bus_oe | output | 1 | Pad output enable |

## Verification
Any pin change reaches the synchronized copies on the 2nd rising edge after it. The state machine acts on it at the 3rd. So `bus_oe` rises on the 3rd edge after a read strobe starts and falls on the 2nd edge after it ends, and a write lands on the 3rd edge after the write strobe ends. The bench drives pins just after falling edges and samples at falling edges. It checks `bus_oe` low after two edges and high after three at the start of a read, and high after one edge and low after two at its end. It holds write data four cycles past the strobe before it reads back. Random transactions in both modes, with and without select and over the whole address space, are compared with a bench model of the register map.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ARMED,
        ST_READ,
        ST_WRITE
    } bus_state_t;
endpackage

// File: rtl/mbs_sync.sv
// Multi-bit synchronizer: every pin goes through the same number of stages
// so strobes and bus values stay aligned.
module mbs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbs_fsm.sv
// Bus-cycle state machine working on synchronized pins.
module mbs_fsm
    import mbs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_s,
    input  logic          cs_s,
    input  logic          as_s,
    input  logic          rdp_s,
    input  logic          wrp_s,
    input  logic [DW-1:0] bus_s,
    output logic [DW-1:0] addr_q,
    output logic          rd_act,
    output logic          wr_act,
    output logic          wr_req,
    output logic          oe
);
    bus_state_t state, nxt;

    // Strobe decode for both conventions.
    always_comb begin
        if (mode_s) begin
            rd_act = rdp_s &  wrp_s;
            wr_act = rdp_s & ~wrp_s;
        end else begin
            rd_act = ~rdp_s;
            wr_act = ~wrp_s;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (as_s) nxt = ST_ADDR;
            ST_ADDR:  if (!as_s) nxt = ST_ARMED;
            ST_ARMED: begin
                if (as_s)                 nxt = ST_ADDR;
                else if (cs_s && rd_act)  nxt = ST_READ;
                else if (cs_s && wr_act)  nxt = ST_WRITE;
            end
            ST_READ: begin
                if (as_s)                 nxt = ST_ADDR;
                else if (!rd_act || !cs_s) nxt = ST_ARMED;
            end
            ST_WRITE: begin
                if (as_s)                 nxt = ST_ADDR;
                else if (!wr_act || !cs_s) nxt = ST_ARMED;
            end
            default:                      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Address latch: taken in the cycle the strobe is seen low in ADDR.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            addr_q <= '0;
        else if (state == ST_ADDR && !as_s)    addr_q <= bus_s;
    end

    always_comb begin
        oe     = 1'b0;
        wr_req = 1'b0;
        unique case (state)
            ST_READ:  oe     = cs_s && rd_act && !as_s;
            ST_WRITE: wr_req = cs_s && !wr_act && !as_s;
            default: begin
                oe     = 1'b0;
                wr_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mbs_regfile.sv
// Read-only status window plus a bank of writable bytes.
module mbs_regfile #(
    parameter int DW       = 8,
    parameter int RO_BASE  = 'h65,
    parameter int RO_COUNT = 7,
    parameter int RW_BASE  = 'h6C,
    parameter int RW_COUNT = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_req,
    input  logic [DW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic [RO_COUNT*DW-1:0] status_in,
    output logic [DW-1:0]          rdata,
    output logic [RW_COUNT*DW-1:0] rw_flat
);
    logic [DW-1:0] regs [RW_COUNT];

    for (genvar i = 0; i < RW_COUNT; i++) begin : g_rw
        localparam logic [DW-1:0] MY_ADDR = DW'(RW_BASE + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          regs[i] <= '0;
            else if (wr_req && addr == MY_ADDR)  regs[i] <= wdata;
        end
        assign rw_flat[i*DW +: DW] = regs[i];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < RO_COUNT; i++)
            if (addr == DW'(RO_BASE + i)) rdata = status_in[i*DW +: DW];
        for (int i = 0; i < RW_COUNT; i++)
            if (addr == DW'(RW_BASE + i)) rdata = regs[i];
    end
endmodule

// File: rtl/mbs_slave.sv
module mbs_slave #(
    parameter int DW       = 8,
    parameter int STAGES   = 2,
    parameter int RO_BASE  = 'h65,
    parameter int RO_COUNT = 7,
    parameter int RW_BASE  = 'h6C,
    parameter int RW_COUNT = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_moto,
    input  logic                   cs_n,
    input  logic                   ale_as,
    input  logic                   rd_ds,
    input  logic                   wr_rw,
    input  logic [DW-1:0]          bus_in,
    input  logic [RO_COUNT*DW-1:0] status_in,
    output logic [DW-1:0]          bus_out,
    output logic                   bus_oe
);
    localparam int SW = DW + 5;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

    logic [SW-1:0] pins_s;
    logic          mode_s, cs_s, as_s, rdp_s, wrp_s;
    logic [DW-1:0] bus_s, addr_q, rdata;
    logic          rd_act, wr_act, wr_req, oe;
    logic [RW_COUNT*DW-1:0] rw_flat;

    mbs_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mode_moto, cs_n, ale_as, rd_ds, wr_rw, bus_in}),
        .q     (pins_s)
    );

    assign mode_s = pins_s[DW+4];
    assign cs_s   = ~pins_s[DW+3];
    assign as_s   = pins_s[DW+2];
    assign rdp_s  = pins_s[DW+1];
    assign wrp_s  = pins_s[DW];
    assign bus_s  = pins_s[DW-1:0];

    mbs_fsm #(.DW(DW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_s (mode_s),
        .cs_s   (cs_s),
        .as_s   (as_s),
        .rdp_s  (rdp_s),
        .wrp_s  (wrp_s),
        .bus_s  (bus_s),
        .addr_q (addr_q),
        .rd_act (rd_act),
        .wr_act (wr_act),
        .wr_req (wr_req),
        .oe     (oe)
    );

    mbs_regfile #(
        .DW(DW), .RO_BASE(RO_BASE), .RO_COUNT(RO_COUNT),
        .RW_BASE(RW_BASE), .RW_COUNT(RW_COUNT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .addr      (addr_q),
        .wdata     (bus_s),
        .status_in (status_in),
        .rdata     (rdata),
        .rw_flat   (rw_flat)
    );

    assign bus_oe  = oe;
    assign bus_out = oe ? rdata : '0;
endmodule

// File: rtl/mbs_slave_chk.sv
module mbs_slave_chk #(
    parameter int DW   = 8,
    parameter int RW_W = 160
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_oe,
    input logic [DW-1:0]   bus_out,
    input logic            as_s,
    input logic            cs_s,
    input logic            rd_act,
    input logic            wr_act,
    input logic            wr_req,
    input logic [DW-1:0]   addr_q,
    input logic [RW_W-1:0] rw_flat
);
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_out == '0);

    assert_oe_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> ($past(rd_act) && $past(cs_s)));

    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> (!rd_act || !cs_s || as_s));

    assert_write_trailing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (!wr_act && $past(wr_act)));

    assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(rw_flat));

    assert_addr_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> (!$past(as_s) && $past(as_s, 2)));
endmodule

bind mbs_slave mbs_slave_chk #(.DW(DW), .RW_W(RW_COUNT*DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_oe  (bus_oe),
    .bus_out (bus_out),
    .as_s    (as_s),
    .cs_s    (cs_s),
    .rd_act  (rd_act),
    .wr_act  (wr_act),
    .wr_req  (wr_req),
    .addr_q  (addr_q),
    .rw_flat (rw_flat)
);

// File: tb/mbs_slave_bench.sv
`timescale 1ns/1ps
module mbs_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_moto = 1'b0;
    logic        cs_n = 1'b1;
    logic        ale_as = 1'b0;
    logic        rd_ds = 1'b1;
    logic        wr_rw = 1'b1;
    logic [7:0]  bus_in = 8'h00;
    logic [55:0] status_in = 56'h0;
    logic [7:0]  bus_out;
    logic        bus_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] model [20];

    always #2.5 clk = ~clk;

    mbs_slave u_mbs_slave (
        .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .cs_n(cs_n),
        .ale_as(ale_as), .rd_ds(rd_ds), .wr_rw(wr_rw), .bus_in(bus_in),
        .status_in(status_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a >= 8'h65 && a <= 8'h6B) return status_in[(a - 8'h65)*8 +: 8];
        if (a >= 8'h6C && a <= 8'h7F) return model[a - 8'h6C];
        return 8'h00;
    endfunction

    task automatic set_mode(input bit m);
        cs_n = 1'b1;
        mode_moto = m;
        rd_ds = m ? 1'b0 : 1'b1;
        wr_rw = 1'b1;
        wait_n(4);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        bus_in = a;
        ale_as = 1'b1;
        wait_n(3);
        check(bus_oe == 1'b0, "R10", "oe in address phase", bus_oe, 0);
        ale_as = 1'b0;
        wait_n(3);
        check(bus_oe == 1'b0, "R10", "oe after address phase", bus_oe, 0);
    endtask

    task automatic do_read(input logic [7:0] a, input bit sel, input string req);
        logic [7:0] e;
        addr_phase(a);
        bus_in = 8'($urandom);
        cs_n = ~sel;
        if (mode_moto) begin wr_rw = 1'b1; rd_ds = 1'b1; end
        else rd_ds = 1'b0;
        wait_n(2);
        check(bus_oe == 1'b0, "R4", "oe two edges into read", bus_oe, 0);
        wait_n(1);
        e = sel ? exp_read(a) : 8'h00;
        check(bus_oe == sel, sel ? "R4" : "R8", "oe third edge into read", bus_oe, sel);
        check(bus_out == e, req, "read data", bus_out, e);
        wait_n(2);
        rd_ds = mode_moto ? 1'b0 : 1'b1;
        wait_n(1);
        check(bus_oe == sel, "R5", "oe one edge after release", bus_oe, sel);
        wait_n(1);
        check(bus_oe == 1'b0, "R5", "oe two edges after release", bus_oe, 0);
        check(bus_out == 8'h00, "R4", "idle bus_out", bus_out, 0);
        cs_n = 1'b1;
        wait_n(2);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit sel);
        addr_phase(a);
        bus_in = d;
        cs_n = ~sel;
        if (mode_moto) begin
            wr_rw = 1'b0;
            wait_n(1);
            rd_ds = 1'b1;
        end else wr_rw = 1'b0;
        wait_n(4);
        check(bus_oe == 1'b0, "R3", "oe during write", bus_oe, 0);
        if (mode_moto) rd_ds = 1'b0; else wr_rw = 1'b1;
        wait_n(4);
        wr_rw = 1'b1;
        cs_n = 1'b1;
        if (sel && a >= 8'h6C && a <= 8'h7F) model[a - 8'h6C] = d;
        wait_n(2);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog expired actual=%0d expected=0", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 20; i++) model[i] = 8'h00;
        status_in = {$urandom, $urandom};
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);

        // R9: reset state
        check(bus_oe == 1'b0, "R9", "oe after reset", bus_oe, 0);
        check(bus_out == 8'h00, "R9", "bus_out after reset", bus_out, 0);
        do_read(8'h6C, 1'b1, "R9");
        do_read(8'h7F, 1'b1, "R9");

        // R1/R3: write and read back in mode 0
        do_write(8'h70, 8'hA5, 1'b1);
        do_read(8'h70, 1'b1, "R3");
        // R1: same register via mode 1
        set_mode(1'b1);
        do_read(8'h70, 1'b1, "R1");
        do_write(8'h7F, 8'h3C, 1'b1);
        do_read(8'h7F, 1'b1, "R1");
        set_mode(1'b0);
        do_read(8'h7F, 1'b1, "R1");

        // R6: status window edges
        do_read(8'h65, 1'b1, "R6");
        do_read(8'h6B, 1'b1, "R6");
        // R7: write to read-only ignored, unmapped reads zero
        do_write(8'h66, 8'hFF, 1'b1);
        do_read(8'h66, 1'b1, "R7");
        do_write(8'h64, 8'h77, 1'b1);
        do_read(8'h64, 1'b1, "R7");
        do_read(8'hC3, 1'b1, "R7");
        // R8: deselected write and read
        do_write(8'h70, 8'h11, 1'b0);
        do_read(8'h70, 1'b1, "R8");
        do_read(8'h70, 1'b0, "R8");
        // R2: address latched on fall, later bus ignored (data phase overwrites bus)
        do_write(8'h6C, 8'h6D, 1'b1);
        do_read(8'h6C, 1'b1, "R2");
        do_read(8'h6D, 1'b1, "R2");

        // Random mix
        for (int t = 0; t < 400; t++) begin
            logic [7:0] a;
            bit sel, rd;
            if ($urandom_range(0, 15) == 0) set_mode(~mode_moto);
            if ($urandom_range(0, 31) == 0) status_in = {$urandom, $urandom};
            a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(8'h60, 8'h7F));
            sel = ($urandom_range(0, 7) != 0);
            rd = $urandom_range(0, 1) == 1;
            if (rd) do_read(a, sel, "R3");
            else    do_write(a, 8'($urandom), sel);
        end
        for (int i = 0; i < 20; i++) do_read(8'(8'h6C + i), 1'b1, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule